// File: doc/BRIEF.md
# ADC Calibration Sequencing Controller

This block sequences the four calibration operations of a sigma-delta converter. Software writes a 3-bit mode field together with a channel select, a chop setting, an excitation bit and two filter-shortcut bits. A write that carries a calibration mode starts an operation. The controller then counts output-rate ticks until the length set by the mode and the chop setting is reached. While it counts it holds a ready indicator high and forces the filter shortcuts off. It also masks ac excitation for the internal modes.

On the tick that completes the count, the controller stores the conversion result that comes with that tick. The result goes into the offset register (zero-scale modes) or the gain register (full-scale modes) of the selected channel. In the same cycle the mode field returns to 000. The conversion result is a plain data input that `rate_tick` qualifies. There is no back-pressure: a result is taken only on the completing tick of a calibration, and every other tick is dropped. Writes that arrive while a calibration runs are dropped in full.

Top module: `calseq_ctrl`

## Requirements
- R1: After reset, `cal_busy` is 0, `mode_q` is 000, `chop_q` is 1, every offset register holds `OFS_RST` (default 24'h800000) and every gain register holds `GAIN_RST` (default 24'h5A5A5A).
- R2: A write while `cal_busy` is 0 whose mode bit 2 is set (codes 100 internal zero-scale, 101 internal full-scale, 110 system zero-scale, 111 system full-scale) sets `cal_busy` from the next cycle, and `mode_q` shows the written code.
- R3: With chop set to 1, a calibration takes 22 `rate_tick` pulses for codes 100, 110 and 111, and 44 pulses for code 101. Clock cycles without a tick do not advance the count. `cal_busy` is 0 in the cycle after the completing tick and 1 before that.
- R4: With chop set to 0, the same lengths are 24 pulses for codes 100, 110 and 111, and 48 pulses for code 101.
- R5: When a calibration completes, `mode_q` reads 000.
- R6: Codes 100 and 110 load `conv_data`, as sampled on the completing tick, into the offset register of the selected channel. No other offset or gain register changes.
- R7: Codes 101 and 111 load `conv_data`, as sampled on the completing tick, into the gain register of the selected channel. No other register changes.
- R8: A write while `cal_busy` is 1 is ignored. Mode, channel and chop stay as they were, and the running calibration keeps its length.
- R9: `fast_eff` and `skip_eff` are 0 while `cal_busy` is 1. Otherwise they follow the written fast and skip bits.
- R10: `ac_eff` is 0 during an internal calibration (codes 100 and 101). During a system calibration (codes 110 and 111), and when idle, it follows the written ac bit.
- R11: Codes 000 to 011 are stored in `mode_q` but never set `cal_busy`, and ticks then leave every offset and gain register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register-write strobe |
| wr_mode | input | 3 | Mode field written |
| wr_chan | input | CH_W | Channel select written |
| wr_chop | input | 1 | Chop setting written |
| wr_ac | input | 1 | AC excitation bit written |
| wr_fast | input | 1 | Fast-filter bit written |
| wr_skip | input | 1 | Skip-filter bit written |
| rate_tick | input | 1 | One-cycle output-rate pulse |
| conv_data | input | DW | Conversion result, valid with rate_tick |
| cal_busy | output | 1 | Ready indicator, high during calibration |
| mode_q | output | 3 | Mode field readback |
| chop_q | output | 1 | Chop setting readback |
| ac_eff | output | 1 | Effective ac excitation |
| fast_eff | output | 1 | Effective fast-filter enable |
| skip_eff | output | 1 | Effective skip-filter enable |
| ofs_flat | output | NCH*DW | Offset registers, channel 0 in the low bits |
| gain_flat | output | NCH*DW | Gain registers, channel 0 in the low bits |

## Verification
The bench runs every calibration code on both channels with chop set and cleared, and spaces the ticks irregularly. A counter that was off by one, or that advanced on clock cycles instead of ticks, would drop the ready indicator one tick early or late. A design that ignored chop, or forgot to double the internal full-scale length, would finish at 22 where 24 or 44 is expected. Each run writes a conflicting mode, channel and chop part way through, and the bench checks that the length and the target register did not move. It also checks that the result was written to the register and channel the mode selects, with the data from the final tick and not the one before it. Non-calibration codes are swept to confirm that no ready pulse appears and no coefficient changes.

// File: rtl/calseq_pkg.sv
package calseq_pkg;
  typedef enum logic [2:0] {
    MD_IDLE = 3'b000,
    MD_IZS  = 3'b100,
    MD_IFS  = 3'b101,
    MD_SZS  = 3'b110,
    MD_SFS  = 3'b111
  } cal_mode_e;

  // bit 0 clear: zero-scale (offset); set: full-scale (gain)
  function automatic logic is_full_scale(input logic [2:0] m);
    return m[0];
  endfunction

  // bit 1 clear: internal source, dc excitation forced
  function automatic logic is_internal(input logic [2:0] m);
    return ~m[1];
  endfunction
endpackage

// File: rtl/calseq_cfg_reg.sv
module calseq_cfg_reg #(
  parameter int CH_W = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_mode,
  input  logic [CH_W-1:0] wr_chan,
  input  logic            wr_chop,
  input  logic            wr_ac,
  input  logic            wr_fast,
  input  logic            wr_skip,
  input  logic            busy,
  input  logic            done,
  output logic            start,
  output logic [2:0]      mode_q,
  output logic [CH_W-1:0] chan_q,
  output logic            chop_q,
  output logic            ac_q,
  output logic            fast_q,
  output logic            skip_q
);
  logic accept;

  assign accept = wr_en & ~busy;
  assign start  = accept & wr_mode[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 3'b000;
      chan_q <= '0;
      chop_q <= 1'b1;
      ac_q   <= 1'b0;
      fast_q <= 1'b0;
      skip_q <= 1'b0;
    end else if (accept) begin
      mode_q <= wr_mode;
      chan_q <= wr_chan;
      chop_q <= wr_chop;
      ac_q   <= wr_ac;
      fast_q <= wr_fast;
      skip_q <= wr_skip;
    end else if (done) begin
      mode_q <= 3'b000;
    end
  end
endmodule

// File: rtl/calseq_timer.sv
module calseq_timer
  import calseq_pkg::*;
#(
  parameter int DUR_CHOP   = 22,
  parameter int DUR_NOCHOP = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] start_mode,
  input  logic       start_chop,
  input  logic       rate_tick,
  output logic       busy,
  output logic       done
);
  localparam int DUR_BASE_MAX = (DUR_CHOP > DUR_NOCHOP) ? DUR_CHOP : DUR_NOCHOP;
  localparam int DUR_MAX      = 2 * DUR_BASE_MAX;
  localparam int CNT_W        = $clog2(DUR_MAX + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_q;
  logic [CNT_W-1:0] last_d;

  always_comb begin
    if (start_mode == MD_IFS)
      last_d = start_chop ? CNT_W'(2 * DUR_CHOP - 1) : CNT_W'(2 * DUR_NOCHOP - 1);
    else
      last_d = start_chop ? CNT_W'(DUR_CHOP - 1) : CNT_W'(DUR_NOCHOP - 1);
  end

  assign done = busy & rate_tick & (cnt_q == last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt_q  <= '0;
      last_q <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      cnt_q  <= '0;
      last_q <= last_d;
    end else if (done) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (busy && rate_tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/calseq_override.sv
module calseq_override (
  input  logic busy,
  input  logic internal_src,
  input  logic ac_q,
  input  logic fast_q,
  input  logic skip_q,
  output logic ac_eff,
  output logic fast_eff,
  output logic skip_eff
);
  always_comb begin
    fast_eff = fast_q & ~busy;
    skip_eff = skip_q & ~busy;
    ac_eff   = ac_q & ~(busy & internal_src);
  end
endmodule

// File: rtl/calseq_coef_bank.sv
module calseq_coef_bank #(
  parameter int          NCH      = 2,
  parameter int          DW       = 24,
  parameter int          CH_W     = 1,
  parameter logic [DW-1:0] OFS_RST  = 24'h800000,
  parameter logic [DW-1:0] GAIN_RST = 24'h5A5A5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_ofs,
  input  logic              upd_gain,
  input  logic [CH_W-1:0]   chan,
  input  logic [DW-1:0]     data,
  output logic [NCH*DW-1:0] ofs_flat,
  output logic [NCH*DW-1:0] gain_flat
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel;
    logic [DW-1:0] ofs_q;
    logic [DW-1:0] gain_q;

    assign sel = (chan == CH_W'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ofs_q  <= OFS_RST;
        gain_q <= GAIN_RST;
      end else begin
        if (upd_ofs && sel)  ofs_q  <= data;
        if (upd_gain && sel) gain_q <= data;
      end
    end

    assign ofs_flat[c*DW +: DW]  = ofs_q;
    assign gain_flat[c*DW +: DW] = gain_q;
  end
endmodule

// File: rtl/calseq_ctrl.sv
module calseq_ctrl
  import calseq_pkg::*;
#(
  parameter int            NCH        = 2,
  parameter int            DW         = 24,
  parameter int            CH_W       = (NCH > 1) ? $clog2(NCH) : 1,
  parameter int            DUR_CHOP   = 22,
  parameter int            DUR_NOCHOP = 24,
  parameter logic [DW-1:0] OFS_RST    = 24'h800000,
  parameter logic [DW-1:0] GAIN_RST   = 24'h5A5A5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_mode,
  input  logic [CH_W-1:0]   wr_chan,
  input  logic              wr_chop,
  input  logic              wr_ac,
  input  logic              wr_fast,
  input  logic              wr_skip,
  input  logic              rate_tick,
  input  logic [DW-1:0]     conv_data,
  output logic              cal_busy,
  output logic [2:0]        mode_q,
  output logic              chop_q,
  output logic              ac_eff,
  output logic              fast_eff,
  output logic              skip_eff,
  output logic [NCH*DW-1:0] ofs_flat,
  output logic [NCH*DW-1:0] gain_flat
);
  logic            start;
  logic            done;
  logic [CH_W-1:0] chan_q;
  logic            ac_q;
  logic            fast_q;
  logic            skip_q;
  logic            upd_ofs;
  logic            upd_gain;

  calseq_cfg_reg #(.CH_W(CH_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mode(wr_mode),
    .wr_chan(wr_chan), .wr_chop(wr_chop), .wr_ac(wr_ac),
    .wr_fast(wr_fast), .wr_skip(wr_skip), .busy(cal_busy), .done(done),
    .start(start), .mode_q(mode_q), .chan_q(chan_q), .chop_q(chop_q),
    .ac_q(ac_q), .fast_q(fast_q), .skip_q(skip_q)
  );

  calseq_timer #(.DUR_CHOP(DUR_CHOP), .DUR_NOCHOP(DUR_NOCHOP)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start), .start_mode(wr_mode),
    .start_chop(wr_chop), .rate_tick(rate_tick), .busy(cal_busy), .done(done)
  );

  calseq_override u_ovr (
    .busy(cal_busy), .internal_src(is_internal(mode_q)), .ac_q(ac_q),
    .fast_q(fast_q), .skip_q(skip_q), .ac_eff(ac_eff),
    .fast_eff(fast_eff), .skip_eff(skip_eff)
  );

  assign upd_ofs  = done & ~is_full_scale(mode_q);
  assign upd_gain = done &  is_full_scale(mode_q);

  calseq_coef_bank #(
    .NCH(NCH), .DW(DW), .CH_W(CH_W), .OFS_RST(OFS_RST), .GAIN_RST(GAIN_RST)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .upd_ofs(upd_ofs), .upd_gain(upd_gain),
    .chan(chan_q), .data(conv_data), .ofs_flat(ofs_flat), .gain_flat(gain_flat)
  );
endmodule

// File: rtl/calseq_ctrl_chk.sv
module calseq_ctrl_chk #(
  parameter int NCH  = 2,
  parameter int DW   = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [2:0]        wr_mode,
  input logic              cal_busy,
  input logic [2:0]        mode_q,
  input logic              ac_eff,
  input logic              fast_eff,
  input logic              skip_eff,
  input logic [NCH*DW-1:0] ofs_flat,
  input logic [NCH*DW-1:0] gain_flat
);
  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_busy && wr_en && wr_mode[2]) |=> cal_busy); // R2
  AST_BUSY_HAS_CAL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> mode_q[2]); // R2
  AST_END_CLEARS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy ##1 !cal_busy) |-> (mode_q == 3'b000)); // R5
  AST_BUSY_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |=> (!cal_busy || $stable(mode_q))); // R8
  AST_FILTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> (!fast_eff && !skip_eff)); // R9
  AST_INTERNAL_DC: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && !mode_q[1]) |-> !ac_eff); // R10
  AST_NONCAL_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_busy && wr_en && !wr_mode[2]) |=> !cal_busy); // R11
  AST_IDLE_COEF_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_busy |=> ($stable(ofs_flat) && $stable(gain_flat))); // R11
  AST_ZERO_KEEPS_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && !mode_q[0]) |=> $stable(gain_flat)); // R6
  AST_FULL_KEEPS_OFS: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && mode_q[0]) |=> $stable(ofs_flat)); // R7
endmodule

bind calseq_ctrl calseq_ctrl_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mode(wr_mode),
  .cal_busy(cal_busy), .mode_q(mode_q), .ac_eff(ac_eff),
  .fast_eff(fast_eff), .skip_eff(skip_eff),
  .ofs_flat(ofs_flat), .gain_flat(gain_flat)
);

// File: tb/calseq_ctrl_tb_top.sv
`timescale 1ns/1ps
module calseq_ctrl_tb_top;
  localparam int NCH = 2;
  localparam int DW  = 24;
  localparam logic [DW-1:0] OFS_D  = 24'h800000;
  localparam logic [DW-1:0] GAIN_D = 24'h5A5A5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_mode = '0;
  logic wr_chan = 1'b0;
  logic wr_chop = 1'b0, wr_ac = 1'b0, wr_fast = 1'b0, wr_skip = 1'b0;
  logic rate_tick = 1'b0;
  logic [DW-1:0] conv_data = '0;
  logic cal_busy, chop_q, ac_eff, fast_eff, skip_eff;
  logic [2:0] mode_q;
  logic [NCH*DW-1:0] ofs_flat, gain_flat;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] exp_ofs [NCH];
  logic [DW-1:0] exp_gain [NCH];

  always #4 clk = ~clk;

  calseq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mode(wr_mode),
    .wr_chan(wr_chan), .wr_chop(wr_chop), .wr_ac(wr_ac), .wr_fast(wr_fast),
    .wr_skip(wr_skip), .rate_tick(rate_tick), .conv_data(conv_data),
    .cal_busy(cal_busy), .mode_q(mode_q), .chop_q(chop_q), .ac_eff(ac_eff),
    .fast_eff(fast_eff), .skip_eff(skip_eff),
    .ofs_flat(ofs_flat), .gain_flat(gain_flat)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_coefs(input string req);
    for (int c = 0; c < NCH; c++) begin
      chk({req, " offset"}, 32'(ofs_flat[c*DW +: DW]), 32'(exp_ofs[c]));
      chk({req, " gain"}, 32'(gain_flat[c*DW +: DW]), 32'(exp_gain[c]));
    end
  endtask

  // drive on negedge; the write takes effect at the next posedge; sample at the negedge after
  task automatic do_write(input logic [2:0] m, input logic ch, input logic cp,
                          input logic ac, input logic fs, input logic sk);
    @(negedge clk);
    wr_en = 1'b1; wr_mode = m; wr_chan = ch; wr_chop = cp;
    wr_ac = ac; wr_fast = fs; wr_skip = sk;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_tick(input logic [DW-1:0] d);
    rate_tick = 1'b1; conv_data = d;
    @(negedge clk);
    rate_tick = 1'b0; conv_data = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      exp_ofs[c] = OFS_D;
      exp_gain[c] = GAIN_D;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(cal_busy), 0);
    chk("R1 mode", 32'(mode_q), 0);
    chk("R1 chop", 32'(chop_q), 1);
    chk_coefs("R1");

    for (int cp = 1; cp >= 0; cp--) begin
      for (int m = 4; m < 8; m++) begin
        for (int ch = 0; ch < NCH; ch++) begin
          int dur;
          int early;
          logic [DW-1:0] d;
          dur = (cp != 0) ? 22 : 24;
          if (m == 5) dur = 2 * dur;
          early = 0;
          d = '0;
          do_write(3'(m), 1'(ch), 1'(cp), 1'b1, 1'b1, 1'b1);
          chk("R2 busy after start", 32'(cal_busy), 1);
          chk("R2 mode readback", 32'(mode_q), 32'(m));
          chk("R9 fast forced off", 32'(fast_eff), 0);
          chk("R9 skip forced off", 32'(skip_eff), 0);
          chk("R10 ac during cal", 32'(ac_eff), (m >= 6) ? 1 : 0);
          for (int k = 1; k <= dur; k++) begin
            repeat (k % 3) @(negedge clk);
            if (k == 5) begin
              do_write(3'b001, 1'(~ch), 1'(~cp), 1'b0, 1'b0, 1'b0);
              chk("R8 mode kept", 32'(mode_q), 32'(m));
              chk("R8 busy kept", 32'(cal_busy), 1);
            end
            d = 24'((m << 20) ^ (ch << 16) ^ (cp << 12) ^ (k * 37));
            pulse_tick(d);
            if (k < dur && cal_busy !== 1'b1) early++;
          end
          chk((cp != 0) ? "R3 no early finish" : "R4 no early finish", 32'(early), 0);
          chk((cp != 0) ? "R3 busy drops on last tick" : "R4 busy drops on last tick",
              32'(cal_busy), 0);
          chk("R5 mode cleared", 32'(mode_q), 0);
          chk("R8 chop kept", 32'(chop_q), 32'(cp));
          if (m[0] == 1'b0) exp_ofs[ch] = d;
          else exp_gain[ch] = d;
          chk_coefs((m[0] == 1'b0) ? "R6" : "R7");
          chk("R9 fast follows when idle", 32'(fast_eff), 1);
          chk("R10 ac follows when idle", 32'(ac_eff), 1);
        end
      end
    end

    // R11 non-calibration codes
    for (int m = 0; m < 4; m++) begin
      do_write(3'(m), 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
      chk("R11 no busy", 32'(cal_busy), 0);
      chk("R11 mode stored", 32'(mode_q), 32'(m));
      chk("R9 skip idle", 32'(skip_eff), 1);
      for (int k = 0; k < 50; k++) pulse_tick(24'(k * 1111 + m));
      chk("R11 still idle", 32'(cal_busy), 0);
      chk_coefs("R11");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule